// File: doc/BRIEF.md
# Servo Pulse Width Quantizer

This block watches a pulse-width-modulated control line meant for a hobby servo. It measures the frame period and the high time of each frame in system clock cycles. It then reduces the high time to one of six coarse angle codes spaced 30 degrees apart. A frame whose period lies outside a fixed window around the nominal 20 ms frame is discarded. A code is reported only when the measurement has changed since the frame before, so a steady servo command produces one report and then silence.

The line enters through a synchronizer chain and is treated as an asynchronous input. All time thresholds are written in microseconds in the package. They are turned into cycle counts at elaboration from the `CLK_HZ` parameter, which gives the rate at which the counters advance. The default is a scaled-down rate that keeps frames short for simulation. A real instance sets it to its actual clock frequency.

Top module: `servo_pulse_quantizer`

## Requirements
- R1: A measurement completes at each rising edge of the line after the first. Its period is the number of clock cycles since the previous rising edge. Its width is the number of cycles from that previous rising edge to the falling edge between them. Because both edges pass through the same synchronizer, a line driven in step with the clock gives exact counts.
- R2: A measurement is accepted only when its period lies from 15 ms to 25 ms, both ends included. These are 1500 and 2500 cycles at the default `CLK_HZ` of 100000. A rejected measurement never raises `angle_vld_o`.
- R3: The width maps to the angle byte as follows. Below 0.9 ms gives 0. From 0.9 ms to below 1.2 ms gives 30. From 1.2 ms to below 1.5 ms gives 60. From 1.5 ms to below 1.8 ms gives 90. From 1.8 ms to below 2.1 ms gives 120. 2.1 ms or more gives 150. At the default rate the band edges are 90, 120, 150, 180 and 210 cycles, and the byte carries the angle in degrees as an unsigned binary number.
- R4: An accepted measurement is reported only if its period or its width differs from the measurement just before it. Every measurement, accepted or rejected, becomes the new comparison point. The first measurement after reset always counts as changed.
- R5: `angle_vld_o` is high for exactly one cycle per report, together with the new byte. `angle_o` holds its value between reports.
- R6: The cycle counter saturates at 2^CNT_W-1 instead of wrapping. At the default rate that value is 8191, above the window. A line that stays still for longer than that yields a period outside the window.
- R7: After reset `angle_o` is 0 and `angle_vld_o` is 0. The first rising edge after reset only starts timing and produces no measurement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; counts advance once per rising edge |
| rst | input | 1 | Synchronous active-high reset |
| pwm_i | input | 1 | Servo control line, asynchronous to clk |
| angle_o | output | 8 | Last reported angle in degrees (0, 30, 60, 90, 120, 150) |
| angle_vld_o | output | 1 | One-cycle strobe marking a new report on angle_o |

## Verification
The hardest situation to reach is a saturated counter. It needs a line that stays idle for several thousand cycles and then starts again. That long measurement lands outside the window, yet it still replaces the comparison point, so the next normal frame must be reported even if it repeats an earlier one. The stimulus reaches this with one directed frame whose low phase runs past saturation, followed by a nominal frame. Directed frames also sit on each side of every width band edge and every window edge, and repeat frames back to back to show that reports are suppressed. Random frames around the window, with deliberate repeats, cover the rest.

// File: rtl/spq_pkg.sv
package spq_pkg;

    // Width band edges in microseconds, ascending; each edge crossed adds 30 degrees.
    localparam int unsigned N_BANDS = 5;
    localparam int unsigned BAND_US [N_BANDS] = '{900, 1200, 1500, 1800, 2100};

    // Accepted frame window in microseconds, inclusive.
    localparam int unsigned WIN_LO_US = 15000;
    localparam int unsigned WIN_HI_US = 25000;

    typedef enum logic [7:0] {
        ANG_0   = 8'd0,
        ANG_30  = 8'd30,
        ANG_60  = 8'd60,
        ANG_90  = 8'd90,
        ANG_120 = 8'd120,
        ANG_150 = 8'd150
    } angle_e;

    typedef struct packed {
        logic   vld;
        angle_e ang;
    } report_t;

    function automatic longint unsigned us_to_cyc(input int unsigned hz, input int unsigned us);
        longint unsigned prod;
        prod = longint'(hz) * longint'(us);
        return prod / 64'd1000000;
    endfunction

    // Counter width: one bit beyond what the window upper edge needs.
    function automatic int unsigned cnt_width(input int unsigned hz);
        return $clog2(us_to_cyc(hz, WIN_HI_US) + 2) + 1;
    endfunction

    function automatic angle_e level_to_angle(input logic [2:0] lvl);
        case (lvl)
            3'd0:    return ANG_0;
            3'd1:    return ANG_30;
            3'd2:    return ANG_60;
            3'd3:    return ANG_90;
            3'd4:    return ANG_120;
            default: return ANG_150;
        endcase
    endfunction

endpackage

// File: rtl/spq_sync_edge.sv
module spq_sync_edge #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic line_i,
    output logic rise_o,
    output logic fall_o
);
    logic [STAGES-1:0] chain_q;
    logic              last_q;
    logic              level;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) chain_q <= '0;
                else     chain_q <= line_i;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) chain_q <= '0;
                else     chain_q <= {chain_q[STAGES-2:0], line_i};
            end
        end
    endgenerate

    assign level = chain_q[STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) last_q <= 1'b0;
        else     last_q <= level;
    end

    assign rise_o = level & ~last_q;
    assign fall_o = ~level & last_q;

endmodule

// File: rtl/spq_measure.sv
module spq_measure #(
    parameter int unsigned CNT_W = 13
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rise_i,
    input  logic             fall_i,
    output logic             meas_v_o,
    output logic [CNT_W-1:0] meas_per_o,
    output logic [CNT_W-1:0] meas_wid_o
);
    localparam logic [CNT_W-1:0] CNT_SAT = '1;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] wid_q;
    logic             armed_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q      <= '0;
            wid_q      <= '0;
            armed_q    <= 1'b0;
            meas_v_o   <= 1'b0;
            meas_per_o <= '0;
            meas_wid_o <= '0;
        end else begin
            meas_v_o <= 1'b0;
            if (rise_i) begin
                cnt_q   <= CNT_W'(1);
                armed_q <= 1'b1;
                if (armed_q) begin
                    meas_v_o   <= 1'b1;
                    meas_per_o <= cnt_q;
                    meas_wid_o <= wid_q;
                end
            end else if (cnt_q != CNT_SAT) begin
                cnt_q <= cnt_q + CNT_W'(1);
            end
            if (fall_i) wid_q <= cnt_q;
        end
    end

    // R6: once at the ceiling the counter stays there until a rising edge
    a_r6_no_wrap: assert property (@(posedge clk) disable iff (rst)
        (cnt_q == CNT_SAT && !rise_i) |=> (cnt_q == CNT_SAT));

    // R7: the edge that arms the timer never yields a measurement
    a_r7_arm_silent: assert property (@(posedge clk) disable iff (rst)
        $rose(armed_q) |-> !meas_v_o);

    // R1: measurements are at least two cycles apart (a fall separates rises)
    a_r1_meas_spacing: assert property (@(posedge clk) disable iff (rst)
        meas_v_o |=> !meas_v_o);

endmodule

// File: rtl/spq_classify.sv
module spq_classify
    import spq_pkg::*;
#(
    parameter int unsigned CLK_HZ = 100_000,
    parameter int unsigned CNT_W  = 13
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             meas_v_i,
    input  logic [CNT_W-1:0] meas_per_i,
    input  logic [CNT_W-1:0] meas_wid_i,
    output report_t          rep_o
);
    localparam logic [CNT_W-1:0] PER_LO = CNT_W'(us_to_cyc(CLK_HZ, WIN_LO_US));
    localparam logic [CNT_W-1:0] PER_HI = CNT_W'(us_to_cyc(CLK_HZ, WIN_HI_US));

    logic [N_BANDS-1:0] above;
    logic [2:0]         lvl;
    angle_e             ang;
    logic               in_win;
    logic               changed;

    logic [CNT_W-1:0]   prev_per_q;
    logic [CNT_W-1:0]   prev_wid_q;
    logic               have_prev_q;
    report_t            rep_q;

    generate
        for (genvar b = 0; b < N_BANDS; b++) begin : g_band
            localparam logic [CNT_W-1:0] EDGE = CNT_W'(us_to_cyc(CLK_HZ, BAND_US[b]));
            assign above[b] = (meas_wid_i >= EDGE);
        end
    endgenerate

    always_comb begin
        lvl     = 3'($countones(above));
        ang     = level_to_angle(lvl);
        in_win  = (meas_per_i >= PER_LO) && (meas_per_i <= PER_HI);
        changed = !have_prev_q || (meas_per_i != prev_per_q) || (meas_wid_i != prev_wid_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_per_q  <= '0;
            prev_wid_q  <= '0;
            have_prev_q <= 1'b0;
            rep_q.vld   <= 1'b0;
            rep_q.ang   <= ANG_0;
        end else begin
            rep_q.vld <= 1'b0;
            if (meas_v_i) begin
                prev_per_q  <= meas_per_i;
                prev_wid_q  <= meas_wid_i;
                have_prev_q <= 1'b1;
                if (in_win && changed) begin
                    rep_q.vld <= 1'b1;
                    rep_q.ang <= ang;
                end
            end
        end
    end

    assign rep_o = rep_q;

    // R2: a report always follows a measurement whose period sat in the window
    a_r2_window: assert property (@(posedge clk) disable iff (rst)
        rep_q.vld |-> ($past(meas_v_i) && ($past(meas_per_i) >= PER_LO)
                       && ($past(meas_per_i) <= PER_HI)));

    // R4: a report never repeats the comparison point it replaced
    a_r4_changed: assert property (@(posedge clk) disable iff (rst)
        (rep_q.vld && $past(have_prev_q)) |->
            (($past(meas_per_i) != $past(prev_per_q)) || ($past(meas_wid_i) != $past(prev_wid_q))));

    // R5: one-cycle strobe, byte steady between strobes
    a_r5_one_cycle: assert property (@(posedge clk) disable iff (rst)
        rep_q.vld |=> !rep_q.vld);
    a_r5_hold: assert property (@(posedge clk) disable iff (rst)
        !rep_q.vld |-> $stable(rep_q.ang));

    // R3: only the six defined codes appear
    a_r3_legal_code: assert property (@(posedge clk) disable iff (rst)
        rep_q.vld |-> (rep_q.ang inside {ANG_0, ANG_30, ANG_60, ANG_90, ANG_120, ANG_150}));

endmodule

// File: rtl/servo_pulse_quantizer.sv
module servo_pulse_quantizer
    import spq_pkg::*;
#(
    parameter int unsigned CLK_HZ      = 100_000,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       pwm_i,
    output logic [7:0] angle_o,
    output logic       angle_vld_o
);
    localparam int unsigned CNT_W = cnt_width(CLK_HZ);

    logic             rise;
    logic             fall;
    logic             meas_v;
    logic [CNT_W-1:0] meas_per;
    logic [CNT_W-1:0] meas_wid;
    report_t          rep;

    spq_sync_edge #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk    (clk),
        .rst    (rst),
        .line_i (pwm_i),
        .rise_o (rise),
        .fall_o (fall)
    );

    spq_measure #(
        .CNT_W (CNT_W)
    ) u_meas (
        .clk        (clk),
        .rst        (rst),
        .rise_i     (rise),
        .fall_i     (fall),
        .meas_v_o   (meas_v),
        .meas_per_o (meas_per),
        .meas_wid_o (meas_wid)
    );

    spq_classify #(
        .CLK_HZ (CLK_HZ),
        .CNT_W  (CNT_W)
    ) u_cls (
        .clk        (clk),
        .rst        (rst),
        .meas_v_i   (meas_v),
        .meas_per_i (meas_per),
        .meas_wid_i (meas_wid),
        .rep_o      (rep)
    );

    assign angle_o     = rep.ang;
    assign angle_vld_o = rep.vld;

endmodule

// File: tb/servo_pulse_quantizer_tb.sv
module servo_pulse_quantizer_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       pwm = 1'b0;
    logic [7:0] angle;
    logic       vld;

    int vectors = 0;
    int miscompares = 0;
    bit done = 1'b0;

    int strobes = 0;
    int seen_ang = 0;

    int exp_strobes = 0;
    int exp_ang = 0;
    int prev_p = 0;
    int prev_w = 0;
    bit have_prev = 1'b0;

    int last_p = 0;
    int last_h = 0;
    string last_tag = "";
    bit have_frame = 1'b0;

    always #5 clk = ~clk;

    servo_pulse_quantizer u_dut (
        .clk         (clk),
        .rst         (rst),
        .pwm_i       (pwm),
        .angle_o     (angle),
        .angle_vld_o (vld)
    );

    always @(negedge clk) begin
        if (!rst && vld) begin
            strobes  <= strobes + 1;
            seen_ang <= int'(angle);
        end
    end

    function automatic int exp_angle(input int w);
        if (w < 90)  return 0;
        if (w < 120) return 30;
        if (w < 150) return 60;
        if (w < 180) return 90;
        if (w < 210) return 120;
        return 150;
    endfunction

    function automatic bit exp_in_win(input int p);
        return (p >= 1500) && (p <= 2500);
    endfunction

    task automatic chk(input string tag, input string what, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic model_meas(input int p, input int w);
        int ps;
        ps = (p > 8191) ? 8191 : p;
        if (exp_in_win(ps) && (!have_prev || ps != prev_p || w != prev_w)) begin
            exp_strobes++;
            exp_ang = exp_angle(w);
        end
        prev_p = ps;
        prev_w = w;
        have_prev = 1'b1;
    endtask

    task automatic drive_frame(input int p, input int h);
        pwm = 1'b1;
        repeat (h) @(negedge clk);
        pwm = 1'b0;
        repeat (p - h) @(negedge clk);
    endtask

    // Drives a frame; its rising edge completes the measurement of the frame before.
    task automatic run(input int p, input int h, input string tag);
        drive_frame(p, h);
        if (have_frame) begin
            model_meas(last_p, last_h);
            chk(last_tag, "strobe count", strobes, exp_strobes);
            chk(last_tag, "angle", seen_ang, exp_ang);
            chk(last_tag, "held angle_o", int'(angle), exp_ang);
        end
        last_p = p;
        last_h = h;
        last_tag = tag;
        have_frame = 1'b1;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            miscompares++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R7: reset state
        chk("R7", "reset angle_o", int'(angle), 0);
        chk("R7", "reset angle_vld_o", int'(vld), 0);

        // R7: first edge only arms; checked after the second frame starts
        drive_frame(2000, 150);
        chk("R7", "strobes after arming frame", strobes, 0);
        last_p = 2000; last_h = 150; last_tag = "R4 first measurement"; have_frame = 1'b1;

        run(2000, 150, "R4 repeat suppressed");
        run(2000, 89,  "R3 width 89 -> 0");
        run(2000, 90,  "R3 width 90 -> 30");
        run(2000, 119, "R3 width 119 -> 30");
        run(2000, 120, "R3 width 120 -> 60");
        run(2000, 149, "R3 width 149 -> 60");
        run(2000, 150, "R3 width 150 -> 90");
        run(2000, 179, "R3 width 179 -> 90");
        run(2000, 180, "R3 width 180 -> 120");
        run(2000, 209, "R3 width 209 -> 120");
        run(2000, 210, "R3 width 210 -> 150");
        run(2000, 1,   "R1 width 1 cycle");
        run(1499, 100, "R2 period 1499 rejected");
        run(1500, 100, "R2 period 1500 accepted");
        run(2500, 100, "R2 period 2500 accepted");
        run(2501, 100, "R2 period 2501 rejected");
        run(2501, 100, "R2 rejected repeat");
        run(2000, 100, "R4 change after rejected");
        run(2001, 100, "R4 period-only change");
        run(2001, 100, "R5 hold on repeat");
        run(9000, 100, "R6 saturated period rejected");
        run(2000, 100, "R6 frame after saturation reported");
        run(1800, 200, "R1 exact counts");

        for (int i = 0; i < 30; i++) begin
            int p;
            int h;
            if ($urandom_range(0, 3) == 0) begin
                p = last_p;
                h = last_h;
            end else begin
                p = int'($urandom_range(1450, 2550));
                h = int'($urandom_range(1, 300));
            end
            run(p, h, "R3 random frame");
        end

        // Final rising edge closes the last measurement.
        run(2000, 50, "R5 closing frame");

        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

endmodule